// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 64-bit packed-integer execution unit. Each operand is viewed as eight bytes, four halfwords, two words or one doubleword, chosen by an element-size input. The unit performs lane-wise add and subtract in wrap, signed-saturating or unsigned-saturating form. It also provides equality and signed greater-than masks, per-lane shifts, full-width bitwise logic, saturating narrowing pack, low/high interleave unpack, and 16-bit multiply-low, multiply-high and multiply-add. No carry, borrow or shifted bit ever crosses a lane boundary.

An issuing pipeline drives both sources, an operation code, the element size and a saturation mode, and raises `in_valid` for one cycle per operation. The result is registered: it appears, together with `out_valid`, one clock after the request, and it is held while no request arrives. No state machine is involved. The only sequential state is the result register and the valid flag. After reset both are cleared, and the unit returns to that state on any reset.

Top module: `simd_alu`

## Requirements
- R1: Element size codes are 0 byte (8 lanes), 1 halfword (4), 2 word (2) and 3 doubleword (1). Operation 0 adds and operation 1 subtracts per lane. With saturation code 0 or 3 the lane result wraps modulo its width, and no carry or borrow leaves a lane.
- R2: With saturation code 1, add and subtract treat lanes as two's complement and clamp an out-of-range result to the lane's most positive or most negative value.
- R3: With saturation code 2, add and subtract treat lanes as unsigned and clamp to all ones on carry out or to zero on borrow.
- R4: Operation 2 writes all ones into each lane whose two elements are equal. Operation 3 does the same where the first element is greater as a signed number. Every other lane becomes zero.
- R5: Operation 4 narrows each signed source element to half width. Size code 1 narrows halfwords to bytes and size code 2 narrows words to halfwords. The first source fills the low half of the result and the second source fills the high half, each in lane order. Saturation code 2 clamps to the unsigned range and any other code clamps to the signed range. Size codes 0 and 3 give zero.
- R6: Operation 5 interleaves the lower-half elements of both sources, and operation 6 interleaves their upper-half elements. Result lane 2i comes from the first source and lane 2i+1 from the second. This applies to size codes 0 to 2, and size code 3 gives zero.
- R7: Operations 7, 8 and 9 work on four signed 16-bit lane pairs. Operation 7 returns the low 16 bits of each product and operation 8 returns the high 16 bits. Operation 9 adds products 0 and 1 into the low 32 bits and products 2 and 3 into the high 32 bits, wrapping.
- R8: Operations 10, 11 and 12 shift each lane of the first source left logically, right logically or right arithmetically. The count is the whole second source as an unsigned number. A count at or above the lane width gives zero, or sign fill for the arithmetic shift.
- R9: Operations 13, 14, 15 and 16 compute AND, AND with the first source inverted, OR and XOR over all 64 bits.
- R10: `result` and `out_valid` update on the clock edge that samples `in_valid` high. When `in_valid` is low, `out_valid` falls the next cycle and `result` holds its value.
- R11: After reset, `result` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 5 | Operation code |
| esz | input | 2 | Element size code |
| sat | input | 2 | Saturation mode code |
| src_a | input | 64 | First source |
| src_b | input | 64 | Second source, or the shift count |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Registered result |

## Verification
The embedded properties check the valid pipeline and result holding (R10), and they do so every cycle. They also check on every cycle that the equality and greater-than masks never overlap, that an unsigned saturating doubleword add never returns less than its first operand, and that a left shift by a count of 64 or more produces zero. Lane isolation, exact clamp values, pack and unpack lane ordering, and product bit selection can only be shown by the bench. It compares every result against its own lane-by-lane model, using directed boundary operands and random operands.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int XLEN   = 64;
    localparam int NSIZES = 4;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_CMPEQ = 5'd2,
        OP_CMPGT = 5'd3,
        OP_PACK  = 5'd4,
        OP_UNPLO = 5'd5,
        OP_UNPHI = 5'd6,
        OP_MULLO = 5'd7,
        OP_MULHI = 5'd8,
        OP_MADD  = 5'd9,
        OP_SHL   = 5'd10,
        OP_SHR   = 5'd11,
        OP_SRA   = 5'd12,
        OP_AND   = 5'd13,
        OP_ANDN  = 5'd14,
        OP_OR    = 5'd15,
        OP_XOR   = 5'd16
    } simd_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } simd_size_e;

    typedef enum logic [1:0] {
        SAT_WRAP  = 2'd0,
        SAT_SGN   = 2'd1,
        SAT_UNS   = 2'd2,
        SAT_WRAP2 = 2'd3
    } simd_sat_e;

endpackage

// File: rtl/simd_addcmp.sv
module simd_addcmp
    import simd_alu_pkg::*;
#(
    parameter int W_DATA = XLEN
) (
    input  logic [W_DATA-1:0] a,
    input  logic [W_DATA-1:0] b,
    input  logic [1:0]        esz,
    input  logic              is_sub,
    input  simd_sat_e         sat,
    output logic [W_DATA-1:0] addsub,
    output logic [W_DATA-1:0] eq_mask,
    output logic [W_DATA-1:0] gt_mask
);

    logic [W_DATA-1:0] as_by_size [NSIZES];
    logic [W_DATA-1:0] eq_by_size [NSIZES];
    logic [W_DATA-1:0] gt_by_size [NSIZES];

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int LW = 8 << g;
        localparam int NL = W_DATA / LW;
        logic [W_DATA-1:0] as_v;
        logic [W_DATA-1:0] eq_v;
        logic [W_DATA-1:0] gt_v;

        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0]        x;
            logic [LW-1:0]        y;
            logic [LW-1:0]        r;
            logic [LW:0]          uwide;
            logic signed [LW:0]   swide;

            assign x = a[l*LW +: LW];
            assign y = b[l*LW +: LW];

            always_comb begin
                if (is_sub) begin
                    uwide = {1'b0, x} - {1'b0, y};
                    swide = $signed({x[LW-1], x}) - $signed({y[LW-1], y});
                end else begin
                    uwide = {1'b0, x} + {1'b0, y};
                    swide = $signed({x[LW-1], x}) + $signed({y[LW-1], y});
                end
                r = uwide[LW-1:0];
                if (sat == SAT_SGN) begin
                    if (swide[LW] != swide[LW-1]) begin
                        r = swide[LW] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
                    end else begin
                        r = swide[LW-1:0];
                    end
                end else if (sat == SAT_UNS && uwide[LW]) begin
                    r = is_sub ? '0 : '1;
                end
            end

            assign as_v[l*LW +: LW] = r;
            assign eq_v[l*LW +: LW] = {LW{x == y}};
            assign gt_v[l*LW +: LW] = {LW{$signed(x) > $signed(y)}};
        end

        assign as_by_size[g] = as_v;
        assign eq_by_size[g] = eq_v;
        assign gt_by_size[g] = gt_v;
    end

    assign addsub  = as_by_size[esz];
    assign eq_mask = eq_by_size[esz];
    assign gt_mask = gt_by_size[esz];

endmodule

// File: rtl/simd_shift.sv
module simd_shift
    import simd_alu_pkg::*;
#(
    parameter int W_DATA = XLEN
) (
    input  logic [W_DATA-1:0] a,
    input  logic [W_DATA-1:0] cnt,
    input  logic [1:0]        esz,
    output logic [W_DATA-1:0] shl,
    output logic [W_DATA-1:0] shr,
    output logic [W_DATA-1:0] sra
);

    logic [W_DATA-1:0] shl_by_size [NSIZES];
    logic [W_DATA-1:0] shr_by_size [NSIZES];
    logic [W_DATA-1:0] sra_by_size [NSIZES];

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int LW = 8 << g;
        localparam int NL = W_DATA / LW;
        localparam int SB = $clog2(LW);
        logic              big;
        logic [SB-1:0]     amt;
        logic [W_DATA-1:0] l_v;
        logic [W_DATA-1:0] r_v;
        logic [W_DATA-1:0] s_v;

        assign big = (cnt >= W_DATA'(LW));
        assign amt = cnt[SB-1:0];

        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] x;
            assign x = a[l*LW +: LW];
            assign l_v[l*LW +: LW] = big ? '0 : (x << amt);
            assign r_v[l*LW +: LW] = big ? '0 : (x >> amt);
            assign s_v[l*LW +: LW] = big ? {LW{x[LW-1]}} : LW'($signed(x) >>> amt);
        end

        assign shl_by_size[g] = l_v;
        assign shr_by_size[g] = r_v;
        assign sra_by_size[g] = s_v;
    end

    assign shl = shl_by_size[esz];
    assign shr = shr_by_size[esz];
    assign sra = sra_by_size[esz];

endmodule

// File: rtl/simd_permute.sv
module simd_permute
    import simd_alu_pkg::*;
#(
    parameter int W_DATA = XLEN
) (
    input  logic [W_DATA-1:0] a,
    input  logic [W_DATA-1:0] b,
    input  logic [1:0]        esz,
    input  logic              usat,
    output logic [W_DATA-1:0] packed_r,
    output logic [W_DATA-1:0] unp_lo,
    output logic [W_DATA-1:0] unp_hi
);

    logic [W_DATA-1:0] pk_by_size [NSIZES];
    logic [W_DATA-1:0] lo_by_size [NSIZES];
    logic [W_DATA-1:0] hi_by_size [NSIZES];

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int LW = 8 << g;
        localparam int NL = W_DATA / LW;
        localparam int HL = NL / 2;
        localparam int HW = LW / 2;

        // interleave: lanes of the chosen half alternate a, b
        if (g < NSIZES - 1) begin : g_unpack
            logic [W_DATA-1:0] lo_v;
            logic [W_DATA-1:0] hi_v;
            for (genvar i = 0; i < HL; i++) begin : g_pair
                assign lo_v[(2*i)*LW   +: LW] = a[i*LW +: LW];
                assign lo_v[(2*i+1)*LW +: LW] = b[i*LW +: LW];
                assign hi_v[(2*i)*LW   +: LW] = a[(HL+i)*LW +: LW];
                assign hi_v[(2*i+1)*LW +: LW] = b[(HL+i)*LW +: LW];
            end
            assign lo_by_size[g] = lo_v;
            assign hi_by_size[g] = hi_v;
        end else begin : g_no_unpack
            assign lo_by_size[g] = '0;
            assign hi_by_size[g] = '0;
        end

        // narrowing: only halfword and word sources
        if (g == 1 || g == 2) begin : g_pack
            logic [W_DATA-1:0] pk_v;
            for (genvar j = 0; j < 2*NL; j++) begin : g_elem
                logic [LW-1:0] v;
                logic [HW-1:0] r;
                if (j < NL) begin : g_from_a
                    assign v = a[j*LW +: LW];
                end else begin : g_from_b
                    assign v = b[(j-NL)*LW +: LW];
                end
                always_comb begin
                    if (usat) begin
                        if (v[LW-1]) begin
                            r = '0;
                        end else if (|v[LW-2:HW]) begin
                            r = '1;
                        end else begin
                            r = v[HW-1:0];
                        end
                    end else begin
                        if ((&v[LW-1:HW-1]) || !(|v[LW-1:HW-1])) begin
                            r = v[HW-1:0];
                        end else begin
                            r = v[LW-1] ? {1'b1, {(HW-1){1'b0}}} : {1'b0, {(HW-1){1'b1}}};
                        end
                    end
                end
                assign pk_v[j*HW +: HW] = r;
            end
            assign pk_by_size[g] = pk_v;
        end else begin : g_no_pack
            assign pk_by_size[g] = '0;
        end
    end

    assign packed_r = pk_by_size[esz];
    assign unp_lo   = lo_by_size[esz];
    assign unp_hi   = hi_by_size[esz];

endmodule

// File: rtl/simd_mul16.sv
module simd_mul16
    import simd_alu_pkg::*;
#(
    parameter int W_DATA = XLEN
) (
    input  logic [W_DATA-1:0] a,
    input  logic [W_DATA-1:0] b,
    output logic [W_DATA-1:0] mul_lo,
    output logic [W_DATA-1:0] mul_hi,
    output logic [W_DATA-1:0] mul_add
);

    localparam int ML = W_DATA / 16;

    logic signed [31:0] prod [ML];

    for (genvar l = 0; l < ML; l++) begin : g_lane
        assign prod[l] = $signed(a[l*16 +: 16]) * $signed(b[l*16 +: 16]);
        assign mul_lo[l*16 +: 16] = prod[l][15:0];
        assign mul_hi[l*16 +: 16] = prod[l][31:16];
    end

    for (genvar k = 0; k < ML/2; k++) begin : g_pairsum
        assign mul_add[k*32 +: 32] = prod[2*k] + prod[2*k+1];
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [4:0]  op,
    input  logic [1:0]  esz,
    input  logic [1:0]  sat,
    input  logic [63:0] src_a,
    input  logic [63:0] src_b,
    output logic        out_valid,
    output logic [63:0] result
);

    simd_op_e   op_e;
    simd_sat_e  sat_e;
    logic [XLEN-1:0] addsub_r, eq_r, gt_r;
    logic [XLEN-1:0] shl_r, shr_r, sra_r;
    logic [XLEN-1:0] pack_r, unlo_r, unhi_r;
    logic [XLEN-1:0] mlo_r, mhi_r, madd_r;
    logic [XLEN-1:0] next_result;

    assign op_e  = simd_op_e'(op);
    assign sat_e = simd_sat_e'(sat);

    simd_addcmp #(.W_DATA(XLEN)) u_addcmp (
        .a(src_a), .b(src_b), .esz(esz), .is_sub(op_e == OP_SUB), .sat(sat_e),
        .addsub(addsub_r), .eq_mask(eq_r), .gt_mask(gt_r)
    );

    simd_shift #(.W_DATA(XLEN)) u_shift (
        .a(src_a), .cnt(src_b), .esz(esz),
        .shl(shl_r), .shr(shr_r), .sra(sra_r)
    );

    simd_permute #(.W_DATA(XLEN)) u_permute (
        .a(src_a), .b(src_b), .esz(esz), .usat(sat_e == SAT_UNS),
        .packed_r(pack_r), .unp_lo(unlo_r), .unp_hi(unhi_r)
    );

    simd_mul16 #(.W_DATA(XLEN)) u_mul (
        .a(src_a), .b(src_b),
        .mul_lo(mlo_r), .mul_hi(mhi_r), .mul_add(madd_r)
    );

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB: next_result = addsub_r;
            OP_CMPEQ:       next_result = eq_r;
            OP_CMPGT:       next_result = gt_r;
            OP_PACK:        next_result = pack_r;
            OP_UNPLO:       next_result = unlo_r;
            OP_UNPHI:       next_result = unhi_r;
            OP_MULLO:       next_result = mlo_r;
            OP_MULHI:       next_result = mhi_r;
            OP_MADD:        next_result = madd_r;
            OP_SHL:         next_result = shl_r;
            OP_SHR:         next_result = shr_r;
            OP_SRA:         next_result = sra_r;
            OP_AND:         next_result = src_a & src_b;
            OP_ANDN:        next_result = ~src_a & src_b;
            OP_OR:          next_result = src_a | src_b;
            OP_XOR:         next_result = src_a ^ src_b;
            default:        next_result = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_result;
            end
        end
    end

    // R10: valid travels exactly one register stage
    p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R4: a lane cannot be both equal and greater
    p_cmp_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ((eq_r & gt_r) == '0));

    // R3: unsigned saturating add never drops below its first operand
    p_usat_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_ADD && sat_e == SAT_UNS && esz == 2'd3)
            |=> (result >= $past(src_a)));

    // R8: oversized left shift empties every lane
    p_big_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_SHL && src_b >= 64'd64) |=> (result == '0));

endmodule

// File: tb/test_simd_alu.sv
module test_simd_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [1:0]  esz = '0;
    logic [1:0]  sat = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    simd_alu i_simd_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esz(esz),
        .sat(sat), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] lmask(int w);
        return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] lane(logic [63:0] v, int i, int w);
        return (v >> (i * w)) & lmask(w);
    endfunction

    function automatic logic signed [65:0] sx(logic [63:0] v, int w);
        logic [63:0] m = lmask(w);
        if (v[w-1]) return $signed({2'b11, v | ~m});
        return $signed({2'b00, v});
    endfunction

    function automatic logic signed [65:0] clamp(logic signed [65:0] v,
                                                 logic signed [65:0] lo,
                                                 logic signed [65:0] hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [63:0] model(int opc, int sz, int sm, logic [63:0] a, logic [63:0] b);
        logic [63:0] res = '0;
        int w = 8 << sz;
        int n = 64 / w;
        logic [63:0] m = lmask(w);
        logic signed [65:0] x, y, s, lo, hi;
        logic signed [65:0] psum [2];
        psum[0] = '0;
        psum[1] = '0;
        case (opc)
            0, 1: for (int i = 0; i < n; i++) begin
                if (sm == 1) begin
                    x = sx(lane(a, i, w), w);
                    y = sx(lane(b, i, w), w);
                    s = (opc == 1) ? x - y : x + y;
                    lo = -(66'sd1 <<< (w - 1));
                    hi = (66'sd1 <<< (w - 1)) - 66'sd1;
                    s = clamp(s, lo, hi);
                end else begin
                    x = $signed({2'b00, lane(a, i, w)});
                    y = $signed({2'b00, lane(b, i, w)});
                    s = (opc == 1) ? x - y : x + y;
                    if (sm == 2) s = clamp(s, 66'sd0, $signed({2'b00, m}));
                end
                res |= (s[63:0] & m) << (i * w);
            end
            2: for (int i = 0; i < n; i++)
                if (lane(a, i, w) == lane(b, i, w)) res |= m << (i * w);
            3: for (int i = 0; i < n; i++)
                if (sx(lane(a, i, w), w) > sx(lane(b, i, w), w)) res |= m << (i * w);
            4: if (sz == 1 || sz == 2) begin
                int hw = w / 2;
                logic [63:0] hm = lmask(hw);
                for (int j = 0; j < 2 * n; j++) begin
                    x = sx((j < n) ? lane(a, j, w) : lane(b, j - n, w), w);
                    if (sm == 2) begin
                        lo = 66'sd0;
                        hi = $signed({2'b00, hm});
                    end else begin
                        lo = -(66'sd1 <<< (hw - 1));
                        hi = (66'sd1 <<< (hw - 1)) - 66'sd1;
                    end
                    x = clamp(x, lo, hi);
                    res |= (x[63:0] & hm) << (j * hw);
                end
            end
            5, 6: if (sz < 3) begin
                int h = n / 2;
                int base = (opc == 6) ? h : 0;
                for (int i = 0; i < h; i++) begin
                    res |= lane(a, base + i, w) << ((2 * i) * w);
                    res |= lane(b, base + i, w) << ((2 * i + 1) * w);
                end
            end
            7, 8, 9: for (int i = 0; i < 4; i++) begin
                s = sx(lane(a, i, 16), 16) * sx(lane(b, i, 16), 16);
                if (opc == 7) res |= {48'd0, s[15:0]} << (16 * i);
                else if (opc == 8) res |= {48'd0, s[31:16]} << (16 * i);
                else psum[i/2] = psum[i/2] + s;
                if (opc == 9 && i == 3)
                    res = {psum[1][31:0], psum[0][31:0]};
            end
            10, 11, 12: for (int i = 0; i < n; i++) begin
                logic [63:0] v = lane(a, i, w);
                logic [63:0] r;
                if (b >= 64'(w)) begin
                    r = (opc == 12 && v[w-1]) ? m : 64'd0;
                end else if (opc == 10) begin
                    r = (v << b) & m;
                end else if (opc == 11) begin
                    r = v >> b;
                end else begin
                    s = sx(v, w) >>> b[6:0];
                    r = s[63:0] & m;
                end
                res |= r << (i * w);
            end
            13: res = a & b;
            14: res = ~a & b;
            15: res = a | b;
            16: res = a ^ b;
            default: res = '0;
        endcase
        return res;
    endfunction

    function automatic string req_of(int opc, int sm);
        case (opc)
            0, 1:     return (sm == 1) ? "R2" : (sm == 2) ? "R3" : "R1";
            2, 3:     return "R4";
            4:        return "R5";
            5, 6:     return "R6";
            7, 8, 9:  return "R7";
            10, 11, 12: return "R8";
            default:  return "R9";
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at a falling edge, sample one cycle later at the next falling edge
    task automatic issue(int opc, int sz, int sm, logic [63:0] a, logic [63:0] b,
                         output logic [63:0] got);
        @(negedge clk);
        in_valid = 1'b1;
        op = 5'(opc);
        esz = 2'(sz);
        sat = 2'(sm);
        src_a = a;
        src_b = b;
        @(negedge clk);
        got = result;
        chk(req_of(opc, sm), result, model(opc, sz, sm, a, b));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        logic [63:0] held;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        chk("R11", result, 64'd0);
        chk("R11", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;

        // R1: byte wrap, no carry into neighbours
        issue(0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, got);
        chk("R1", got, 64'd0);
        chk("R10", {63'd0, out_valid}, 64'd1);
        issue(1, 1, 0, 64'h0000_0001_0000_0005, 64'h0001_0001_0001_0001, got);
        chk("R1", got, 64'hFFFF_0000_FFFF_0004);
        // R2: signed clamps
        issue(0, 0, 1, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, got);
        chk("R2", got, 64'h7F7F_7F7F_7F7F_7F7F);
        issue(1, 0, 1, 64'h8080_8080_8080_8080, 64'h0101_0101_0101_0101, got);
        chk("R2", got, 64'h8080_8080_8080_8080);
        issue(0, 3, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd5, got);
        chk("R2", got, 64'h7FFF_FFFF_FFFF_FFFF);
        // R3: unsigned clamps
        issue(0, 0, 2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, got);
        chk("R3", got, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(1, 2, 2, 64'h0000_0000_0000_0009, 64'h0000_0001_0000_0003, got);
        chk("R3", got, 64'h0000_0000_0000_0006);
        // R4: masks
        issue(2, 1, 0, 64'h0001_0002_0003_0004, 64'h0001_0000_0003_0000, got);
        chk("R4", got, 64'hFFFF_0000_FFFF_0000);
        issue(3, 0, 0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_00FF, got);
        chk("R4", got, 64'h0000_0000_0000_00FF);
        // R5: narrowing
        issue(4, 1, 1, 64'h0100_FF00_007F_0005, 64'd0, got);
        chk("R5", got, 64'h0000_0000_7F80_7F05);
        issue(4, 1, 2, 64'h0100_FF00_007F_0005, 64'd0, got);
        chk("R5", got, 64'h0000_0000_FF00_7F05);
        issue(4, 0, 1, 64'h0100_FF00_007F_0005, 64'h1234, got);
        chk("R5", got, 64'd0);
        // R6: interleave
        issue(5, 0, 0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, got);
        chk("R6", got, 64'h1303_1202_1101_1000);
        issue(6, 0, 0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, got);
        chk("R6", got, 64'h1707_1606_1505_1404);
        issue(5, 3, 0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, got);
        chk("R6", got, 64'd0);
        // R7: products
        issue(9, 1, 0, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, got);
        chk("R7", got, 64'h8000_0000_8000_0000);
        issue(8, 1, 0, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, got);
        chk("R7", got, 64'h4000_4000_4000_4000);
        issue(7, 1, 0, 64'h0003_FFFF_0100_0002, 64'h0005_FFFF_0100_0003, got);
        // R8: shift boundaries
        issue(10, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd16, got);
        chk("R8", got, 64'd0);
        issue(11, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7, got);
        chk("R8", got, 64'h0101_0101_0101_0101);
        issue(12, 2, 0, 64'h8000_0000_0000_0001, 64'd40, got);
        chk("R8", got, 64'hFFFF_FFFF_0000_0000);
        issue(12, 3, 0, 64'h8000_0000_0000_0000, 64'd200, got);
        chk("R8", got, 64'hFFFF_FFFF_FFFF_FFFF);
        // R9: first operand inverted
        issue(14, 0, 0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, got);
        chk("R9", got, 64'h0F00_0F00_0F00_0F00);

        // R10: hold while idle
        held = result;
        @(negedge clk);
        in_valid = 1'b0;
        op = 5'd16;
        src_a = 64'h1234_5678_9ABC_DEF0;
        src_b = 64'hFFFF_0000_FFFF_0000;
        @(negedge clk);
        @(negedge clk);
        chk("R10", result, held);
        chk("R10", {63'd0, out_valid}, 64'd0);

        for (int k = 0; k < 2000; k++) begin
            int ro = int'($urandom % 17);
            int rs = int'($urandom % 4);
            int rm = int'($urandom % 4);
            logic [63:0] ra = {$urandom, $urandom};
            logic [63:0] rb = {$urandom, $urandom};
            if (ro >= 10 && ro <= 12 && ($urandom % 4) != 0) rb = 64'($urandom % 80);
            issue(ro, rs, rm, ra, rb, got);
        end

        @(negedge clk);
        in_valid = 1'b0;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule